// File: doc/BRIEF.md
# Timed-Access Write Guard

This block protects a small bank of control registers against stray software writes. Software first writes a two-byte key to a dedicated unlock address. The two key writes must come one after the other, with no other write between them. A correct key opens a short access window that is counted in machine-cycle ticks. During the window, one write to a protected register takes effect. Outside the window, protected writes are dropped without any indication.

The block sits beside a processor's special-function register decoder. It receives the processor's write strobe, address and data, plus a tick that marks each machine cycle. It drives the contents of the protected registers, a read-data port, and a flag that shows whether the window is open. Reads are never gated.

Top module: `timed_write_guard`

## Requirements
- R1: After reset the window is closed (`win_open_o`=0). Protected register 0 holds 8'h3C and register 1 holds 8'h81; `prot_q_o` is therefore 16'h813C, with register i at bits [8i+7:8i].
- R2: While idle, a write of 8'hAA to the unlock address 8'hC7 arms the sequencer. A write of any other value to 8'hC7 leaves it idle.
- R3: `win_open_o` rises after the clock edge that captures a write of 8'h55 to 8'hC7, and only when that write is the next write after the 8'hAA key. Any other write, to any address, aborts the sequence to idle.
- R4: The window stays open for exactly 3 ticks. It closes at the edge that captures the third `tick_i` pulse counted after opening.
- R5: A write to a protected address (8'hC8 + i, for i = 0..1) updates register i at the next edge only if the window is open. Otherwise the register keeps its value.
- R6: After one protected write is accepted, the window closes and the sequencer returns to idle.
- R7: The window counter advances only on cycles where `tick_i` is high. Clock cycles without a tick leave the window open.
- R8: `rd_data_o` shows register i for `rd_addr_i` = 8'hC8 + i, whatever the window state. It reads 0 at 8'hC7 and at every other address.
- R9: If a protected write and the window-closing tick fall in the same cycle, the write is accepted and the window closes.
- R10: A write to 8'hC7 while the window is open closes it. If the value is 8'hAA the sequencer is re-armed; any other value returns it to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Machine-cycle tick, one clock wide |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| prot_q_o | output | 16 | Protected register contents |
| win_open_o | output | 1 | Access window open |

## Verification
A protected write and the window's final tick can arrive in the same cycle. The outcome must be that the write is accepted and the window closes (R9). The bench provokes this by opening a window, giving two ticks, and then issuing a protected write together with the third tick. It judges the result by reading the register back at the ports and sampling `win_open_o`. A nearby case is also covered: a write issued one tick later, after expiry, must be dropped.

// File: rtl/twg_pkg.sv
package twg_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_OPEN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/twg_key_seq.sv
module twg_key_seq
  import twg_pkg::*;
#(
  parameter logic [7:0] UNLOCK_ADDR = 8'hC7,
  parameter logic [7:0] KEY_FIRST   = 8'hAA,
  parameter logic [7:0] KEY_SECOND  = 8'h55,
  parameter int unsigned WIN_TICKS  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       prot_hit_i,
  output logic       open_o
);
  localparam int unsigned CNT_W = $clog2(WIN_TICKS + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             key_wr;

  assign key_wr = wr_en_i && (wr_addr_i == UNLOCK_ADDR);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (key_wr && wr_data_i == KEY_FIRST) state_d = SEQ_ARMED;
      end
      SEQ_ARMED: begin
        if (wr_en_i) begin
          if (key_wr && wr_data_i == KEY_SECOND) begin
            state_d = SEQ_OPEN;
            cnt_d   = CNT_W'(WIN_TICKS);
          end else begin
            state_d = SEQ_IDLE;
          end
        end
      end
      SEQ_OPEN: begin
        if (key_wr) begin
          // a new key write restarts the sequence
          state_d = (wr_data_i == KEY_FIRST) ? SEQ_ARMED : SEQ_IDLE;
          cnt_d   = '0;
        end else if (prot_hit_i) begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end else if (tick_i) begin
          if (cnt_q == CNT_W'(1)) begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign open_o = (state_q == SEQ_OPEN);

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(key_wr && wr_data_i == KEY_SECOND)); // R3
  AST_OPEN_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |-> (cnt_q != '0 && cnt_q <= CNT_W'(WIN_TICKS))); // R4
  AST_CLOSE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && prot_hit_i) |=> !open_o); // R6
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && !tick_i && !wr_en_i) |=> open_o); // R7
endmodule

// File: rtl/twg_prot_regs.sv
module twg_prot_regs #(
  parameter int unsigned            NUM_PROT  = 2,
  parameter logic [7:0]             PROT_BASE = 8'hC8,
  parameter logic [NUM_PROT*8-1:0]  RST_VAL   = 16'h813C
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  open_i,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [7:0]            rd_addr_i,
  output logic                  hit_o,
  output logic [7:0]            rd_data_o,
  output logic [NUM_PROT*8-1:0] regs_o
);
  logic [NUM_PROT-1:0] wsel;
  logic [NUM_PROT-1:0] rsel;

  for (genvar i = 0; i < NUM_PROT; i++) begin : g_reg
    localparam logic [7:0] REG_ADDR = 8'(PROT_BASE + 8'(i));
    logic [7:0] q;

    assign wsel[i] = wr_en_i && (wr_addr_i == REG_ADDR);
    assign rsel[i] = (rd_addr_i == REG_ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q <= RST_VAL[i*8 +: 8];
      else if (open_i && wsel[i]) q <= wr_data_i;
    end

    assign regs_o[i*8 +: 8] = q;
  end

  assign hit_o = |wsel;

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_PROT; k++) begin
      if (rsel[k]) rd_data_o = regs_o[k*8 +: 8];
    end
  end

  AST_CLOSED_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |=> $stable(regs_o)); // R5
endmodule

// File: rtl/timed_write_guard.sv
module timed_write_guard #(
  parameter logic [7:0]             UNLOCK_ADDR = 8'hC7,
  parameter logic [7:0]             KEY_FIRST   = 8'hAA,
  parameter logic [7:0]             KEY_SECOND  = 8'h55,
  parameter int unsigned            WIN_TICKS   = 3,
  parameter int unsigned            NUM_PROT    = 2,
  parameter logic [7:0]             PROT_BASE   = 8'hC8,
  parameter logic [NUM_PROT*8-1:0]  PROT_RST    = 16'h813C
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [7:0]            rd_addr_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_PROT*8-1:0] prot_q_o,
  output logic                  win_open_o
);
  logic prot_hit;

  twg_key_seq #(
    .UNLOCK_ADDR(UNLOCK_ADDR),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND),
    .WIN_TICKS  (WIN_TICKS)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .prot_hit_i(prot_hit),
    .open_o    (win_open_o)
  );

  twg_prot_regs #(
    .NUM_PROT (NUM_PROT),
    .PROT_BASE(PROT_BASE),
    .RST_VAL  (PROT_RST)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .open_i   (win_open_o),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i),
    .hit_o    (prot_hit),
    .rd_data_o(rd_data_o),
    .regs_o   (prot_q_o)
  );

  AST_UNLOCK_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == UNLOCK_ADDR) |-> (rd_data_o == 8'h00)); // R8
  AST_KEY_WRITE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_open_o && wr_en_i && wr_addr_i == UNLOCK_ADDR) |=> !win_open_o); // R10
endmodule

// File: tb/sim_timed_write_guard.sv
`timescale 1ns/1ps
module sim_timed_write_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = 8'h00;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_addr = 8'h00;
  logic [7:0]  rd_data;
  logic [15:0] prot_q;
  logic        win_open;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_reg [2];

  always #5 clk = ~clk;

  timed_write_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .prot_q_o(prot_q), .win_open_o(win_open)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; drives one cycle, returns at the next negedge
  task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d, input logic t);
    wr_en = we; wr_addr = a; wr_data = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic open_win();
    step(1'b1, 8'hC7, 8'hAA, 1'b0);
    step(1'b1, 8'hC7, 8'h55, 1'b0);
  endtask

  task automatic check_regs(input string req);
    check(req, {16'h0, prot_q}, {16'h0, exp_reg[1], exp_reg[0]});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    exp_reg[0] = 8'h3C;
    exp_reg[1] = 8'h81;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 window", {31'h0, win_open}, 32'h0);
    check_regs("R1 defaults");

    // R2/R3: sweep first key byte
    for (int v = 0; v < 256; v++) begin
      logic ok;
      ok = (v == 8'hAA);
      step(1'b1, 8'hC7, 8'(v), 1'b0);
      step(1'b1, 8'hC7, 8'h55, 1'b0);
      check("R2 first byte", {31'h0, win_open}, {31'h0, ok});
      step(1'b1, 8'hC8, 8'(v ^ 8'h5A), 1'b0);
      if (ok) exp_reg[0] = 8'(v ^ 8'h5A);
      check_regs("R5 gated write");
      check("R6 closed after write", {31'h0, win_open}, 32'h0);
    end

    // R3: sweep second key byte
    for (int v = 0; v < 256; v++) begin
      logic ok;
      ok = (v == 8'h55);
      step(1'b1, 8'hC7, 8'hAA, 1'b0);
      step(1'b1, 8'hC7, 8'(v), 1'b0);
      check("R3 second byte", {31'h0, win_open}, {31'h0, ok});
      step(1'b1, 8'hC9, 8'(~v), 1'b0);
      if (ok) exp_reg[1] = 8'(~v);
      check_regs("R5 gated write");
    end

    // R3: intervening writes abort
    step(1'b1, 8'hC7, 8'hAA, 1'b0);
    step(1'b1, 8'h80, 8'h11, 1'b0);
    step(1'b1, 8'hC7, 8'h55, 1'b0);
    check("R3 abort other addr", {31'h0, win_open}, 32'h0);
    step(1'b1, 8'hC7, 8'hAA, 1'b0);
    step(1'b1, 8'hC8, 8'h99, 1'b0);
    check_regs("R3 dropped protected write while armed");
    step(1'b1, 8'hC7, 8'h55, 1'b0);
    check("R3 abort protected addr", {31'h0, win_open}, 32'h0);
    // idle cycles between keys do not abort
    step(1'b1, 8'hC7, 8'hAA, 1'b0);
    step(1'b0, 8'h00, 8'h00, 1'b1);
    step(1'b1, 8'hC7, 8'h55, 1'b0);
    check("R3 idle gap", {31'h0, win_open}, 32'h1);
    step(1'b1, 8'hC9, 8'h42, 1'b0);
    exp_reg[1] = 8'h42;
    check_regs("R5 write after gap");

    // R4/R7/R9: write after w ticks
    for (int w = 0; w < 5; w++) begin
      logic [7:0] d;
      logic same;
      int done;
      d = 8'(w * 17 + 5);
      done = 0;
      open_win();
      for (int j = 1; j <= w && j <= 2; j++) begin
        step(1'b0, 8'h00, 8'h00, 1'b0);
        step(1'b0, 8'h00, 8'h00, 1'b0);
        check("R7 no tick holds", {31'h0, win_open}, 32'h1);
        step(1'b0, 8'h00, 8'h00, 1'b1);
        done = j;
        check("R4 open after tick", {31'h0, win_open}, 32'h1);
      end
      same = (w == 2);
      if (w >= 3) begin
        step(1'b0, 8'h00, 8'h00, 1'b1);
        check("R4 closes on third tick", {31'h0, win_open}, 32'h0);
        done = 3;
      end
      if (w == 4) step(1'b0, 8'h00, 8'h00, 1'b1);
      step(1'b1, 8'hC8, d, same);
      if (done < 3) exp_reg[0] = d;
      check_regs(same ? "R9 write with last tick" : "R4 write vs window");
      check(same ? "R9 closed" : "R6 closed", {31'h0, win_open}, 32'h0);
    end

    // R10: key write while open
    open_win();
    step(1'b1, 8'hC7, 8'hAA, 1'b0);
    check("R10 AA closes", {31'h0, win_open}, 32'h0);
    step(1'b1, 8'hC7, 8'h55, 1'b0);
    check("R10 rearmed", {31'h0, win_open}, 32'h1);
    step(1'b1, 8'hC7, 8'h12, 1'b0);
    check("R10 other closes", {31'h0, win_open}, 32'h0);
    step(1'b1, 8'hC7, 8'h55, 1'b0);
    check("R10 idle after other", {31'h0, win_open}, 32'h0);
    step(1'b1, 8'hC9, 8'hEE, 1'b0);
    check_regs("R10 dropped write");

    // R8: read sweep, window closed and open
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) begin
        open_win();
        check("R8 window open", {31'h0, win_open}, 32'h1);
      end
      for (int a = 0; a < 256; a++) begin
        logic [7:0] e;
        rd_addr = 8'(a);
        #1;
        e = (a == 8'hC8) ? exp_reg[0] : (a == 8'hC9) ? exp_reg[1] : 8'h00;
        check("R8 read", {24'h0, rd_data}, {24'h0, e});
      end
      rd_addr = 8'h00;
      @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule